// File: doc/BRIEF.md
# Chained DMA Descriptor Fetch Unit

This unit brings one descriptor of a chained transfer list out of memory and into a DMA channel's working registers. The channel engine pulses a start request with the current descriptor pointer. This happens when a transfer begins in list mode, and again when a transfer finishes while more descriptors are pending. The unit then issues four single-word reads through a simple read master, one at a time. It keeps the returned words, and in a single clock it updates the channel's mode bits, total size, source and destination addresses, current-descriptor address and descriptor pointer.

The first word of a descriptor is its control word. It carries the total transfer size in bits 11:0, the address-increment and port-select bits in bits 19:16, and a last-descriptor flag in bit 20. The other three words are the source address, the destination address and the link to the following descriptor. The chunk-size half of the channel size register is not part of the descriptor. It is taken from the channel as it stands and passed through unchanged. A `more_o` output tells the engine whether the list continues after this descriptor.

Top module: `dl_desc_loader`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_req_o`, `more_o` are low and `mode_o`, `size_o`, `src_o`, `dst_o`, `desc_ptr_o`, `cur_desc_o` are zero.
- R2: A load performs exactly four reads, at pointer+0x0 (control), +0x4 (source), +0x8 (destination), +0xC (next link), in that order. A request holds its address until accepted (`rd_req_o` and `rd_rdy_i` high on a clock edge), and the next request waits for the previous word's `rd_valid_i`.
- R3: `more_o` is the inverse of control word bit 20 (1 = last descriptor).
- R4: `mode_o[0]`, `mode_o[1]`, `mode_o[2]` and `mode_o[3]` take control word bits 16 (source increment), 17 (destination increment), 18 (source select) and 19 (destination select).
- R5: `size_o[11:0]` takes control word bits 11:0, and `size_o[23:12]` takes `size_i[23:12]` (chunk size) unchanged.
- R6: `src_o` takes the word read at +0x4 and `dst_o` the word read at +0x8.
- R7: `cur_desc_o` takes the pointer the load started from, and `desc_ptr_o` takes the word read at +0xC.
- R8: `done_o` is high for exactly one cycle per load, in the first cycle the updated values are visible. Outside that cycle the channel outputs hold their value.
- R9: A start request while a load is in progress is ignored: the address sequence and the recorded current-descriptor address still follow the pointer of the first start.
- R10: `busy_o` is high from the cycle after an accepted start until the cycle `done_o` is high, in which it is low. `rd_req_o` is only high while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load request from the channel engine |
| ptr_i | input | AW | Descriptor pointer sampled at start |
| size_i | input | TOT_W+CHK_W | Current channel size register (chunk half passed through) |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read byte address |
| rd_rdy_i | input | 1 | Read request accepted |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DW | Read data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle load completion pulse |
| more_o | output | 1 | List continues after this descriptor |
| mode_o | output | 4 | {dst select, src select, dst increment, src increment} |
| size_o | output | TOT_W+CHK_W | Updated channel size register |
| src_o | output | AW | Source address |
| dst_o | output | AW | Destination address |
| desc_ptr_o | output | AW | Next descriptor pointer |
| cur_desc_o | output | AW | Address of the descriptor just loaded |

## Verification
The bench goes after read ordering under random acceptance stalls and random return delays. A design that advanced the address on issue instead of on data return, or dropped a stalled address, would read the wrong words and put them in the wrong registers. It drives control words with the last-descriptor flag set and clear, all-ones and all-zero mode bits, and the extreme sizes 0 and 0xFFF. Swapped bits or a clobbered chunk field then show up directly on `mode_o` and `size_o`. It also fires a second start with a different pointer in the middle of a load. A design that restarted would read from the second pointer or report it as the current descriptor.

// File: rtl/dl_pkg.sv
package dl_pkg;
  // control word field positions (a neighbour decodes these)
  localparam int CW_INC_SRC = 16;
  localparam int CW_INC_DST = 17;
  localparam int CW_SEL_SRC = 18;
  localparam int CW_SEL_DST = 19;
  localparam int CW_LAST    = 20;

  localparam int NUM_WORDS = 4;

  // word order inside a descriptor; fetched strictly in this order
  typedef enum logic [1:0] {
    W_CTRL = 2'd0,
    W_SRC  = 2'd1,
    W_DST  = 2'd2,
    W_LINK = 2'd3
  } word_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } fsm_e;

  typedef struct packed {
    logic sel_dst;
    logic sel_src;
    logic inc_dst;
    logic inc_src;
  } mode_t;
endpackage

// File: rtl/dl_fetch.sv
module dl_fetch
  import dl_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] ptr_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_rdy_i,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          word_vld_o,
  output word_e         word_idx_o,
  output logic [DW-1:0] word_o,
  output logic [AW-1:0] base_o,
  output logic          done_o
);
  localparam int WORD_BYTES = DW / 8;
  localparam int BSH        = $clog2(WORD_BYTES);

  fsm_e          state_q;
  word_e         idx_q;
  logic [AW-1:0] base_q;
  logic          last_word;
  logic [1:0]    idx_nxt;

  assign last_word  = (idx_q == W_LINK);
  assign idx_nxt    = 2'(idx_q) + 2'd1;
  assign word_vld_o = (state_q == S_WAIT) && rd_valid_i;
  assign word_idx_o = idx_q;
  assign word_o     = rd_data_i;
  assign base_o     = base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      idx_q     <= W_CTRL;
      base_q    <= '0;
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            base_q    <= ptr_i;
            idx_q     <= W_CTRL;
            rd_req_o  <= 1'b1;
            rd_addr_o <= ptr_i;
            busy_o    <= 1'b1;
            state_q   <= S_REQ;
          end
        end
        S_REQ: begin
          if (rd_rdy_i) begin
            rd_req_o <= 1'b0;
            state_q  <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (rd_valid_i) begin
            if (last_word) begin
              busy_o  <= 1'b0;
              done_o  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              idx_q     <= word_e'(idx_nxt);
              rd_req_o  <= 1'b1;
              rd_addr_o <= base_q + (AW'(idx_nxt) << BSH);
              state_q   <= S_REQ;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dl_decode.sv
module dl_decode
  import dl_pkg::*;
#(
  parameter int DW    = 32,
  parameter int TOT_W = 12
) (
  input  logic [DW-1:0]    cw_i,
  output mode_t            mode_o,
  output logic [TOT_W-1:0] tot_o,
  output logic             last_o
);
  assign mode_o.inc_src = cw_i[CW_INC_SRC];
  assign mode_o.inc_dst = cw_i[CW_INC_DST];
  assign mode_o.sel_src = cw_i[CW_SEL_SRC];
  assign mode_o.sel_dst = cw_i[CW_SEL_DST];
  assign last_o         = cw_i[CW_LAST];
  assign tot_o          = cw_i[TOT_W-1:0];

  logic unused_cw;
  assign unused_cw = ^{cw_i[DW-1:CW_LAST+1], cw_i[CW_INC_SRC-1:TOT_W]};
endmodule

// File: rtl/dl_chanregs.sv
module dl_chanregs
  import dl_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TOT_W = 12,
  parameter int CHK_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   word_vld_i,
  input  word_e                  word_idx_i,
  input  logic [DW-1:0]          word_i,
  input  logic [AW-1:0]          base_i,
  input  logic [CHK_W-1:0]       chunk_i,
  input  mode_t                  mode_i,
  input  logic [TOT_W-1:0]       tot_i,
  input  logic                   last_i,
  output logic [DW-1:0]          cw_o,
  output mode_t                  mode_o,
  output logic [TOT_W+CHK_W-1:0] size_o,
  output logic [AW-1:0]          src_o,
  output logic [AW-1:0]          dst_o,
  output logic [AW-1:0]          desc_ptr_o,
  output logic [AW-1:0]          cur_desc_o,
  output logic                   more_o
);
  logic [DW-1:0] stage_q [NUM_WORDS-1];
  logic          commit;

  assign commit = word_vld_i && (word_idx_i == W_LINK);
  assign cw_o   = stage_q[W_CTRL];

  // staging registers for the first three words of the descriptor
  for (genvar g = 0; g < NUM_WORDS - 1; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[g] <= '0;
      end else if (word_vld_i && (word_idx_i == word_e'(g))) begin
        stage_q[g] <= word_i;
      end
    end
  end

  // all channel registers move together on the link word
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o     <= '0;
      size_o     <= '0;
      src_o      <= '0;
      dst_o      <= '0;
      desc_ptr_o <= '0;
      cur_desc_o <= '0;
      more_o     <= 1'b0;
    end else if (commit) begin
      mode_o     <= mode_i;
      size_o     <= {chunk_i, tot_i};
      src_o      <= AW'(stage_q[W_SRC]);
      dst_o      <= AW'(stage_q[W_DST]);
      desc_ptr_o <= AW'(word_i);
      cur_desc_o <= base_i;
      more_o     <= ~last_i;
    end
  end
endmodule

// File: rtl/dl_desc_loader.sv
module dl_desc_loader
  import dl_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TOT_W = 12,
  parameter int CHK_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [AW-1:0]          ptr_i,
  input  logic [TOT_W+CHK_W-1:0] size_i,
  output logic                   rd_req_o,
  output logic [AW-1:0]          rd_addr_o,
  input  logic                   rd_rdy_i,
  input  logic                   rd_valid_i,
  input  logic [DW-1:0]          rd_data_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   more_o,
  output logic [3:0]             mode_o,
  output logic [TOT_W+CHK_W-1:0] size_o,
  output logic [AW-1:0]          src_o,
  output logic [AW-1:0]          dst_o,
  output logic [AW-1:0]          desc_ptr_o,
  output logic [AW-1:0]          cur_desc_o
);
  localparam int SZW = TOT_W + CHK_W;

  logic             word_vld;
  word_e            word_idx;
  logic [DW-1:0]    word;
  logic [AW-1:0]    base;
  logic [DW-1:0]    cw;
  mode_t            dec_mode;
  mode_t            reg_mode;
  logic [TOT_W-1:0] dec_tot;
  logic             dec_last;

  dl_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .ptr_i      (ptr_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_rdy_i   (rd_rdy_i),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .busy_o     (busy_o),
    .word_vld_o (word_vld),
    .word_idx_o (word_idx),
    .word_o     (word),
    .base_o     (base),
    .done_o     (done_o)
  );

  dl_decode #(.DW(DW), .TOT_W(TOT_W)) u_decode (
    .cw_i   (cw),
    .mode_o (dec_mode),
    .tot_o  (dec_tot),
    .last_o (dec_last)
  );

  dl_chanregs #(.AW(AW), .DW(DW), .TOT_W(TOT_W), .CHK_W(CHK_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .word_vld_i (word_vld),
    .word_idx_i (word_idx),
    .word_i     (word),
    .base_i     (base),
    .chunk_i    (size_i[SZW-1:TOT_W]),
    .mode_i     (dec_mode),
    .tot_i      (dec_tot),
    .last_i     (dec_last),
    .cw_o       (cw),
    .mode_o     (reg_mode),
    .size_o     (size_o),
    .src_o      (src_o),
    .dst_o      (dst_o),
    .desc_ptr_o (desc_ptr_o),
    .cur_desc_o (cur_desc_o),
    .more_o     (more_o)
  );

  assign mode_o = reg_mode;

  logic unused_size;
  assign unused_size = ^size_i[TOT_W-1:0];
endmodule

// File: rtl/dl_desc_loader_chk.sv
module dl_desc_loader_chk #(
  parameter int AW  = 32,
  parameter int SZW = 24
) (
  input logic           clk,
  input logic           rst,
  input logic           rd_req_o,
  input logic           rd_rdy_i,
  input logic [AW-1:0]  rd_addr_o,
  input logic           busy_o,
  input logic           done_o,
  input logic           more_o,
  input logic [3:0]     mode_o,
  input logic [SZW-1:0] size_o,
  input logic [AW-1:0]  src_o,
  input logic [AW-1:0]  dst_o,
  input logic [AW-1:0]  desc_ptr_o,
  input logic [AW-1:0]  cur_desc_o
);
  // a stalled request keeps its address
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_rdy_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // an accepted request drops until its data returns
  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && rd_rdy_i) |=> !rd_req_o);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_regs_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(src_o) && $stable(dst_o) && $stable(desc_ptr_o) &&
                 $stable(cur_desc_o) && $stable(size_o) && $stable(mode_o) &&
                 $stable(more_o)));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !rd_req_o));

  assert_req_busy_R10: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> busy_o);
endmodule

bind dl_desc_loader dl_desc_loader_chk #(.AW(AW), .SZW(TOT_W + CHK_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_req_o   (rd_req_o),
  .rd_rdy_i   (rd_rdy_i),
  .rd_addr_o  (rd_addr_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .more_o     (more_o),
  .mode_o     (mode_o),
  .size_o     (size_o),
  .src_o      (src_o),
  .dst_o      (dst_o),
  .desc_ptr_o (desc_ptr_o),
  .cur_desc_o (cur_desc_o)
);

// File: tb/tb_dl_desc_loader.sv
module tb_dl_desc_loader;
  localparam int AW = 32, DW = 32, TOT_W = 12, CHK_W = 12, SZW = 24;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start_i = 1'b0;
  logic [AW-1:0]  ptr_i = '0;
  logic [SZW-1:0] size_i = '0;
  logic           rd_req_o;
  logic [AW-1:0]  rd_addr_o;
  logic           rd_rdy_i = 1'b0;
  logic           rd_valid_i = 1'b0;
  logic [DW-1:0]  rd_data_i = '0;
  logic           busy_o, done_o, more_o;
  logic [3:0]     mode_o;
  logic [SZW-1:0] size_o;
  logic [AW-1:0]  src_o, dst_o, desc_ptr_o, cur_desc_o;

  always #2.5 clk = ~clk;

  dl_desc_loader #(.AW(AW), .DW(DW), .TOT_W(TOT_W), .CHK_W(CHK_W)) dut (.*);

  logic [31:0] mem [256];
  logic [31:0] alog [8];
  int          nlog = 0;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory responder: random acceptance, random return delay
  initial begin
    bit          pend = 0;
    int          dly = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      rd_valid_i = 1'b0;
      rd_rdy_i   = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          rd_valid_i = 1'b1;
          rd_data_i  = mem[paddr[9:2]];
          pend = 0;
        end else dly--;
      end else if (!rst && rd_req_o && ($urandom % 3 != 0)) begin
        rd_rdy_i = 1'b1;
        paddr = rd_addr_o;
        if (nlog < 8) alog[nlog] = rd_addr_o;
        nlog++;
        pend = 1;
        dly = int'($urandom % 3);
      end
    end
  end

  function automatic logic [3:0] exp_mode(input logic [31:0] cw);
    return {cw[19], cw[18], cw[17], cw[16]};
  endfunction

  task automatic run_load(input logic [31:0] ptr, input logic [31:0] cw,
                          input logic [11:0] chunk, input bit late_start);
    int wd = 0;
    logic [31:0] w1, w2, w3;
    w1 = $urandom; w2 = $urandom; w3 = $urandom;
    mem[ptr[9:2]]      = cw;
    mem[ptr[9:2] + 1]  = w1;
    mem[ptr[9:2] + 2]  = w2;
    mem[ptr[9:2] + 3]  = w3;
    nlog = 0;
    @(negedge clk);
    ptr_i   = ptr;
    size_i  = {chunk, 12'($urandom)};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after start", 64'(busy_o), 64'd1);
    if (late_start) begin
      @(negedge clk);
      ptr_i   = ptr ^ 32'h100;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o && wd < 400) begin
      @(negedge clk);
      wd++;
    end
    chk(wd < 400, "R8 done reached", 64'(wd), 64'd0);
    chk(busy_o == 1'b0, "R10 busy low at done", 64'(busy_o), 64'd0);
    chk(nlog == 4, "R2 read count", 64'(nlog), 64'd4);
    for (int i = 0; i < 4; i++)
      chk(alog[i] == ptr + 32'(4 * i), late_start ? "R9 address order" : "R2 address order",
          64'(alog[i]), 64'(ptr + 32'(4 * i)));
    chk(more_o == ~cw[20], "R3 more", 64'(more_o), 64'(~cw[20]));
    chk(mode_o == exp_mode(cw), "R4 mode", 64'(mode_o), 64'(exp_mode(cw)));
    chk(size_o == {chunk, cw[11:0]}, "R5 size", 64'(size_o), 64'({chunk, cw[11:0]}));
    chk(src_o == w1, "R6 source", 64'(src_o), 64'(w1));
    chk(dst_o == w2, "R6 destination", 64'(dst_o), 64'(w2));
    chk(desc_ptr_o == w3, "R7 next pointer", 64'(desc_ptr_o), 64'(w3));
    chk(cur_desc_o == ptr, late_start ? "R9 current descriptor" : "R7 current descriptor",
        64'(cur_desc_o), 64'(ptr));
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done one cycle", 64'(done_o), 64'd0);
    chk(src_o == w1 && desc_ptr_o == w3, "R8 outputs hold", 64'(src_o), 64'(w1));
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && rd_req_o == 0 && more_o == 0, "R1 control idle",
        64'({busy_o, done_o, rd_req_o, more_o}), 64'd0);
    chk(mode_o == 0 && size_o == 0 && src_o == 0 && dst_o == 0, "R1 regs zero",
        64'(src_o), 64'd0);
    chk(desc_ptr_o == 0 && cur_desc_o == 0, "R1 pointers zero", 64'(desc_ptr_o), 64'd0);

    // directed corners
    run_load(32'h40, 32'h001F_0FFF, 12'hABC, 0);  // last, all mode bits, max size
    run_load(32'h80, 32'h0000_0000, 12'h000, 0);  // more, no mode bits, size 0
    run_load(32'h3F0, 32'hFFE0_F123, 12'hFFF, 0); // more, all upper junk bits
    run_load(32'h10, 32'h0015_0800, 12'h001, 1);  // start while busy
    run_load(32'h200, 32'h000A_0001, 12'h055, 1);

    // random loads
    for (int n = 0; n < 25; n++)
      run_load(32'(($urandom % 252) * 4), $urandom, 12'($urandom), ($urandom % 4) == 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule